// File: doc/BRIEF.md
# Double-Rate Four-Port RAM Wrapper

This block wraps a two-port RAM and clocks it at twice the rate of the user logic. It derives a phase flag from two phase-aligned clocks, a user clock and a clock at double its rate. With that flag it runs two operations on each physical RAM port in every user cycle. Logic on the user clock therefore sees four logical ports per cycle where a single-rate RAM would give two. The cost is latency: read data is captured in the fast domain and then registered back onto the user clock.

Whether each logical port reads or writes is fixed by a parameter mask. Logical ports 0 and 1 go to the RAM in the first half of a user cycle, and ports 2 and 3 go in the second half. Because of this order, a write on port 0 or 1 is seen by a read on port 2 or 3 in the same user cycle. A second parameter selects a single-rate mode. In that mode the RAM runs on the user clock, port 0 is the only write port, port 1 is the only read port, and read latency is one cycle.

Top module: `dp_ram_pump`

## Requirements
- R1: With PUMP=2, a read requested on a logical read port in user cycle c shows its data on that port's rdata_o after the second rising edge of clk_i that follows the request.
- R2: Bit p of WR_MASK set makes logical port p a write port, and its rdata_o stays zero. Bit p clear makes port p a read port, and a read port's wdata_i never reaches the memory.
- R3: With PUMP=2, ports 0 and 1 access the RAM in the first half of the user cycle and ports 2 and 3 in the second half. A read on port 2 or 3 returns data written on port 0 or 1 in the same user cycle.
- R4: A read issued in the same half as a write, or in an earlier half, returns the value held before that write.
- R5: Every write accepted in user cycle c is visible to any read issued in cycle c+1 or later.
- R6: A read port's rdata_o keeps its last value through any cycle in which that port makes no request.
- R7: While rst_ni is low, every rdata_o is zero. Memory contents are not cleared by reset.
- R8: With PUMP=1, port 0 writes and port 1 reads with a latency of one user cycle (read before write for the same address). Requests on ports 2 and 3 are ignored, and rdata_o of ports 0, 2 and 3 is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | User clock |
| clk2x_i | input | 1 | RAM clock at twice the user rate, rising edges aligned with clk_i |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Per logical port request, a read or a write as the port role defines |
| addr_i | input | 4*AW | Per logical port word address |
| wdata_i | input | 4*DW | Per logical port write data (used by write ports only) |
| rdata_o | output | 4*DW | Per logical port read data, registered on clk_i |

## Verification
The bench builds two instances, both with AW=4 and DW=8. The first uses PUMP=2 and WR_MASK=4'b1001, which gives one write port in each half of the user cycle and one read port in each half. With that layout, a single cycle can show a read that sees a same-cycle write (port 2 after port 0) and a read that does not (port 1 beside port 0, and port 2 beside port 3). The second instance uses PUMP=1 and receives the same stimulus, so it shows the one-cycle latency and shows that ports 2 and 3 are ignored.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  localparam int unsigned NLP = 4;  // logical ports seen by user logic
  localparam int unsigned NPP = 2;  // physical RAM ports
endpackage

// File: rtl/dpm_phase.sv
module dpm_phase (
  input  logic clk_i,
  input  logic clk2x_i,
  input  logic rst_ni,
  output logic first_half_o
);
  logic tgl_slow, tgl_fast;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) tgl_slow <= 1'b0;
    else         tgl_slow <= ~tgl_slow;

  // samples the old slow toggle on the aligned edge, the new one mid-cycle
  always_ff @(posedge clk2x_i or negedge rst_ni)
    if (!rst_ni) tgl_fast <= 1'b0;
    else         tgl_fast <= tgl_slow;

  // high before the mid-cycle fast edge, low before the aligned edge
  assign first_half_o = tgl_slow ^ tgl_fast;
endmodule

// File: rtl/dpm_ram.sv
module dpm_ram import dpm_pkg::*; #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NPP-1:0]          en_i,
  input  logic [NPP-1:0]          we_i,
  input  logic [NPP-1:0][AW-1:0]  addr_i,
  input  logic [NPP-1:0][DW-1:0]  wdata_i,
  output logic [NPP-1:0][DW-1:0]  rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // later port wins on a same-address double write
  always_ff @(posedge clk_i) begin
    for (int i = 0; i < NPP; i++)
      if (en_i[i] && we_i[i]) mem[addr_i[i]] <= wdata_i[i];
  end

  for (genvar g = 0; g < NPP; g++) begin : g_rd
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                    rdata_o[g] <= '0;
      else if (en_i[g] && !we_i[g])   rdata_o[g] <= mem[addr_i[g]];
  end
endmodule

// File: rtl/dpm_sched.sv
module dpm_sched import dpm_pkg::*; #(
  parameter int unsigned   AW      = 4,
  parameter int unsigned   DW      = 8,
  parameter logic [NLP-1:0] WR_MASK = 4'b1001
) (
  input  logic                   first_half_i,
  input  logic [NLP-1:0]         req_i,
  input  logic [NLP-1:0][AW-1:0] addr_i,
  input  logic [NLP-1:0][DW-1:0] wdata_i,
  output logic [NPP-1:0]         en_o,
  output logic [NPP-1:0]         we_o,
  output logic [NPP-1:0][AW-1:0] addr_o,
  output logic [NPP-1:0][DW-1:0] wdata_o
);
  // physical port g serves logical g in the first half, g+NPP in the second
  for (genvar g = 0; g < NPP; g++) begin : g_pp
    localparam int unsigned LO = g;
    localparam int unsigned HI = g + NPP;
    always_comb begin
      if (first_half_i) begin
        en_o[g]    = req_i[LO];
        we_o[g]    = WR_MASK[LO];
        addr_o[g]  = addr_i[LO];
        wdata_o[g] = wdata_i[LO];
      end else begin
        en_o[g]    = req_i[HI];
        we_o[g]    = WR_MASK[HI];
        addr_o[g]  = addr_i[HI];
        wdata_o[g] = wdata_i[HI];
      end
    end
  end
endmodule

// File: rtl/dpm_retime.sv
module dpm_retime import dpm_pkg::*; #(
  parameter int unsigned    DW      = 8,
  parameter logic [NLP-1:0] WR_MASK = 4'b1001
) (
  input  logic                   clk_i,
  input  logic                   clk2x_i,
  input  logic                   rst_ni,
  input  logic                   first_half_i,
  input  logic [NLP-1:0]         req_i,
  input  logic [NPP-1:0][DW-1:0] ram_rd_i,
  output logic [NLP-1:0][DW-1:0] rdata_o
);
  logic [NPP-1:0][DW-1:0] hold_lo, hold_hi;

  // aligned edge parks first-half results, mid edge parks second-half results
  always_ff @(posedge clk2x_i or negedge rst_ni)
    if (!rst_ni) begin
      hold_lo <= '0;
      hold_hi <= '0;
    end else if (first_half_i) begin
      hold_hi <= ram_rd_i;
    end else begin
      hold_lo <= ram_rd_i;
    end

  for (genvar p = 0; p < NLP; p++) begin : g_lp
    localparam int unsigned PP = p % NPP;
    if (WR_MASK[p]) begin : g_wr
      assign rdata_o[p] = '0;
    end else begin : g_rd
      logic          rd_q;
      logic [DW-1:0] src;
      logic [DW-1:0] data_q;
      assign src = (p < NPP) ? hold_lo[PP] : hold_hi[PP];
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          rd_q   <= 1'b0;
          data_q <= '0;
        end else begin
          rd_q <= req_i[p];
          if (rd_q) data_q <= src;
        end
      assign rdata_o[p] = data_q;
    end
  end
endmodule

// File: rtl/dp_ram_pump.sv
module dp_ram_pump import dpm_pkg::*; #(
  parameter int unsigned    AW      = 4,
  parameter int unsigned    DW      = 8,
  parameter int unsigned    PUMP    = 2,
  parameter logic [NLP-1:0] WR_MASK = 4'b1001
) (
  input  logic                   clk_i,
  input  logic                   clk2x_i,
  input  logic                   rst_ni,
  input  logic [NLP-1:0]         req_i,
  input  logic [NLP-1:0][AW-1:0] addr_i,
  input  logic [NLP-1:0][DW-1:0] wdata_i,
  output logic [NLP-1:0][DW-1:0] rdata_o
);
  logic first_half;

  if (PUMP == 2) begin : g_dbl
    logic [NPP-1:0]         ram_en, ram_we;
    logic [NPP-1:0][AW-1:0] ram_addr;
    logic [NPP-1:0][DW-1:0] ram_wdata, ram_rdata;

    dpm_phase u_phase (
      .clk_i        (clk_i),
      .clk2x_i      (clk2x_i),
      .rst_ni       (rst_ni),
      .first_half_o (first_half)
    );

    dpm_sched #(.AW(AW), .DW(DW), .WR_MASK(WR_MASK)) u_sched (
      .first_half_i (first_half),
      .req_i        (req_i),
      .addr_i       (addr_i),
      .wdata_i      (wdata_i),
      .en_o         (ram_en),
      .we_o         (ram_we),
      .addr_o       (ram_addr),
      .wdata_o      (ram_wdata)
    );

    dpm_ram #(.AW(AW), .DW(DW)) u_ram (
      .clk_i   (clk2x_i),
      .rst_ni  (rst_ni),
      .en_i    (ram_en),
      .we_i    (ram_we),
      .addr_i  (ram_addr),
      .wdata_i (ram_wdata),
      .rdata_o (ram_rdata)
    );

    dpm_retime #(.DW(DW), .WR_MASK(WR_MASK)) u_retime (
      .clk_i        (clk_i),
      .clk2x_i      (clk2x_i),
      .rst_ni       (rst_ni),
      .first_half_i (first_half),
      .req_i        (req_i),
      .ram_rd_i     (ram_rdata),
      .rdata_o      (rdata_o)
    );
  end else begin : g_sgl
    logic [NPP-1:0][DW-1:0] ram_rdata;

    assign first_half = 1'b0;

    // single rate: physical port 0 writes for logical 0, port 1 reads for logical 1
    dpm_ram #(.AW(AW), .DW(DW)) u_ram (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (req_i[1:0]),
      .we_i    (2'b01),
      .addr_i  (addr_i[1:0]),
      .wdata_i (wdata_i[1:0]),
      .rdata_o (ram_rdata)
    );

    assign rdata_o[0] = '0;
    assign rdata_o[1] = ram_rdata[1];
    assign rdata_o[2] = '0;
    assign rdata_o[3] = '0;
  end
endmodule

// File: rtl/dpm_chk.sv
module dpm_chk import dpm_pkg::*; #(
  parameter int unsigned    DW      = 8,
  parameter int unsigned    PUMP    = 2,
  parameter logic [NLP-1:0] WR_MASK = 4'b1001
) (
  input logic                   clk_i,
  input logic                   clk2x_i,
  input logic                   rst_ni,
  input logic                   first_half_i,
  input logic [NLP-1:0]         req_i,
  input logic [NLP-1:0][DW-1:0] rdata_o
);
  if (PUMP == 2) begin : g_dbl
    // R3
    phase_at_user_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !first_half_i);
    // R3
    phase_alternates_chk: assert property (@(posedge clk2x_i) disable iff (!rst_ni)
      first_half_i |=> !first_half_i);
    for (genvar p = 0; p < NLP; p++) begin : g_p
      if (WR_MASK[p]) begin : g_w
        // R2
        wr_port_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
          rdata_o[p] == '0);
      end else begin : g_r
        // R6
        idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
          !req_i[p] |=> ##1 $stable(rdata_o[p]));
      end
    end
  end else begin : g_sgl
    // R8
    sgl_unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rdata_o[0] == '0) && (rdata_o[2] == '0) && (rdata_o[3] == '0));
    // R6
    sgl_idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_i[1] |=> $stable(rdata_o[1]));
  end
endmodule

bind dp_ram_pump dpm_chk #(.DW(DW), .PUMP(PUMP), .WR_MASK(WR_MASK)) u_chk (
  .clk_i        (clk_i),
  .clk2x_i      (clk2x_i),
  .rst_ni       (rst_ni),
  .first_half_i (first_half),
  .req_i        (req_i),
  .rdata_o      (rdata_o)
);

// File: tb/tb_dp_ram_pump.sv
`timescale 1ns/100ps
module tb_dp_ram_pump;
  localparam logic [3:0] MASK = 4'b1001;
  localparam int NV = 12;

  typedef struct packed {
    logic [3:0] rq;
    logic [3:0] a0, a1, a2, a3;
    logic [7:0] d0, d1, d2, d3;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{4'b0110, 4'd0, 4'd3, 4'd5, 4'd0, 8'h00, 8'h00, 8'h00, 8'h00},
    '{4'b0101, 4'd7, 4'd0, 4'd7, 4'd0, 8'hA7, 8'h00, 8'h00, 8'h00},
    '{4'b0011, 4'd8, 4'd8, 4'd0, 4'd0, 8'hB8, 8'h00, 8'h00, 8'h00},
    '{4'b0110, 4'd0, 4'd8, 4'd7, 4'd0, 8'h00, 8'h00, 8'h00, 8'h00},
    '{4'b1100, 4'd0, 4'd0, 4'd9, 4'd9, 8'h00, 8'h00, 8'h00, 8'hC9},
    '{4'b0010, 4'd0, 4'd9, 4'd0, 4'd0, 8'h00, 8'h00, 8'h00, 8'h00},
    '{4'b0000, 4'd1, 4'd1, 4'd1, 4'd1, 8'h55, 8'h55, 8'h55, 8'h55},
    '{4'b0110, 4'd0, 4'd0, 4'd1, 4'd0, 8'h00, 8'hEE, 8'hEE, 8'h00},
    '{4'b0110, 4'd0, 4'd1, 4'd0, 4'd0, 8'h00, 8'h00, 8'h00, 8'h00},
    '{4'b1111, 4'd2, 4'd2, 4'd2, 4'd2, 8'hD2, 8'h00, 8'h00, 8'hE2},
    '{4'b0010, 4'd0, 4'd2, 4'd0, 4'd0, 8'h00, 8'h00, 8'h00, 8'h00},
    '{4'b0110, 4'd0, 4'd15, 4'd14, 4'd0, 8'h00, 8'h00, 8'h00, 8'h00}
  };

  logic clk_i = 1'b0, clk2x_i = 1'b1, rst_ni = 1'b0;
  logic [3:0]       req_i = '0;
  logic [3:0][3:0]  addr_i = '0;
  logic [3:0][7:0]  wdata_i = '0;
  logic [3:0][7:0]  rd_d, rd_s;

  always #5   clk_i   = ~clk_i;
  always #2.5 clk2x_i = ~clk2x_i;

  dp_ram_pump #(.AW(4), .DW(8), .PUMP(2), .WR_MASK(MASK)) dut (
    .clk_i, .clk2x_i, .rst_ni, .req_i, .addr_i, .wdata_i, .rdata_o(rd_d));
  dp_ram_pump #(.AW(4), .DW(8), .PUMP(1), .WR_MASK(MASK)) dut_sp (
    .clk_i, .clk2x_i, .rst_ni, .req_i, .addr_i, .wdata_i, .rdata_o(rd_s));

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] m_d [16], m_s [16];
  logic [3:0] log_rq [256];
  logic [7:0] log_vd [256][4];
  logic [7:0] log_vs [256];
  string      log_tag [256];
  string      vtag [NV];
  logic [7:0] exp_d [4];
  logic [7:0] exp_s;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    string t;
    if (cyc >= 2)
      for (int p = 0; p < 4; p++)
        if (log_rq[cyc-2][p] && !MASK[p]) exp_d[p] = log_vd[cyc-2][p];
    if (cyc >= 1 && log_rq[cyc-1][1]) exp_s = log_vs[cyc-1];
    t = (cyc >= 2) ? log_tag[cyc-2] : "R7";
    for (int p = 0; p < 4; p++)
      chk(rd_d[p], exp_d[p], MASK[p] ? "R2" : t, $sformatf("dbl port%0d", p));
    chk(rd_s[1], exp_s, "R8", "sgl port1");
    chk(rd_s[0] | rd_s[2] | rd_s[3], 8'h00, "R8", "sgl unused ports");
  endtask

  task automatic step(input vec_t v, input string tag);
    @(posedge clk_i); #2;
    check_outputs();
    req_i      <= v.rq;
    addr_i     <= {v.a3, v.a2, v.a1, v.a0};
    wdata_i    <= {v.d3, v.d2, v.d1, v.d0};
    // double-rate model: port1 read, port0 write, port2 read, port3 write
    log_vd[cyc][0] = 8'h00;
    log_vd[cyc][3] = 8'h00;
    log_vd[cyc][1] = m_d[v.a1];
    if (v.rq[0]) m_d[v.a0] = v.d0;
    log_vd[cyc][2] = m_d[v.a2];
    if (v.rq[3]) m_d[v.a3] = v.d3;
    // single-rate model: read before write, ports 2 and 3 ignored
    log_vs[cyc] = m_s[v.a1];
    if (v.rq[0]) m_s[v.a0] = v.d0;
    log_rq[cyc]  = v.rq;
    log_tag[cyc] = tag;
    cyc++;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    vec_t idle, w;
    idle = '0;
    vtag = '{"R1", "R3", "R4", "R5", "R4", "R5", "R6", "R2", "R2", "R3", "R5", "R1"};
    for (int p = 0; p < 4; p++) exp_d[p] = 8'h00;
    exp_s = 8'h00;
    repeat (3) @(posedge clk_i);
    #2;
    // R7: reset state
    for (int p = 0; p < 4; p++) chk(rd_d[p], 8'h00, "R7", "dbl in reset");
    chk(rd_s[1], 8'h00, "R7", "sgl in reset");
    rst_ni = 1'b1;
    // fill memory through port 0 (R5: visible to later cycles)
    for (int i = 0; i < 16; i++) begin
      w = '0;
      w.rq = 4'b0001;
      w.a0 = 4'(i);
      w.d0 = 8'h10 + 8'(i);
      step(w, "R5");
    end
    for (int i = 0; i < NV; i++) step(VEC[i], vtag[i]);
    repeat (3) step(idle, "R6");
    // R7: mid-run reset clears outputs only
    @(posedge clk_i); #2;
    check_outputs();
    log_rq[cyc] = '0; log_tag[cyc] = "R6"; cyc++;
    rst_ni = 1'b0;
    #10;
    for (int p = 0; p < 4; p++) chk(rd_d[p], 8'h00, "R7", "dbl after reset");
    chk(rd_s[1], 8'h00, "R7", "sgl after reset");
    for (int p = 0; p < 4; p++) exp_d[p] = 8'h00;
    exp_s = 8'h00;
    rst_ni = 1'b1;
    step(VEC[11], "R7");
    step(VEC[9], "R3");
    repeat (3) step(idle, "R6");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule